// File: doc/BRIEF.md
# Supply Start-Up Supervisor with Hysteresis

This block is a synchronous state machine that brings up a set of internal supply rails in order and then watches them. Analog comparators outside the block report, for each rail, whether it has reached its programmed target or is above roughly 80 percent of it. From those flags the supervisor decides when the supplies are usable. It raises a ready flag, which enables the line drivers elsewhere on the chip, and a busy status pin that is always the inverse of ready. It also drives an enable for the converters, an enable for the charging path of the secondary boost rail, and a request for extra output current on the driver-supply regulator.

Start-up charges the high boost rail first. The charging path for the secondary boost rail opens only after the high rail reports that it is at target. Ready is granted when the high boost rail is at full target, the driver-supply and substrate rails are above 80 percent, and the secondary rail has reached its target at least once. That last condition is latched. Once the block is ready, the 80 percent flags of the high boost, driver-supply and substrate rails are the only conditions it watches. This gives hysteresis between entering and leaving the ready state. A sag below 80 percent on any of these three rails drops ready and restarts the sequence.

Power-down can come from a pin or from a register bit. In power-down the converters are shut off and the secondary-rail latch is cleared. Asynchronous reset of the digital supply also enters power-down. Every comparator flag and the power-down pin pass through a synchronizer before the state machine uses them.

Top module: `rail_startup_supervisor`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block is in power-down: `supply_ready`=0, `start_busy`=1, `conv_en`=0, `aux_chg_en`=0, `drv_boost`=0.
- R2: `pwrdn_reg`=1 forces power-down (`conv_en`=0, `supply_ready`=0, `aux_chg_en`=0, `drv_boost`=0) at the first rising edge. `pwrdn_pin`=1 does the same at the third rising edge.
- R3: `start_busy` is at every cycle the inverse of `supply_ready`.
- R4: Leaving power-down enters the high-rail charge phase: `conv_en`=1 and `aux_chg_en`=0. `aux_chg_en` becomes 1 only after `hi_at`=1 has been seen, and `aux_at` has no effect before that.
- R5: From the secondary-charge phase, `supply_ready` rises when `hi_at`, `drv_80` and `sub_80` are all 1 and the secondary rail has been seen at target (`aux_at`=1, now or before).
- R6: The secondary-rail condition is latched. Dropping `aux_at` while ready has no effect, and a restart after a sag does not need `aux_at` again.
- R7: While ready, `hi_80`, `drv_80` or `sub_80` at 0 drops `supply_ready` and `aux_chg_en` and restarts at the high-rail charge phase.
- R8: While ready, `hi_at`=0 with `hi_80`=1 keeps `supply_ready`=1 (hysteresis).
- R9: With `drv_const_mode`=0, `drv_boost` is 1 during start-up. It becomes 0 when ready is reached or when `base_ok` has been seen in the current start-up, whichever comes first, and it is 1 again after a sag restart.
- R10: With `drv_const_mode`=1, `drv_boost` equals `conv_en` in the same cycle.
- R11: A comparator flag or `pwrdn_pin` change acts on the outputs at the third rising edge after it is applied, through two synchronizer flops and the state register. The high-rail charge phase to ready takes one further edge.
- R12: Leaving power-down clears the latched secondary-rail condition, so ready again requires `aux_at`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the digital supply |
| pwrdn_pin | input | 1 | Power-down request from the package pin (asynchronous, synchronized) |
| pwrdn_reg | input | 1 | Power-down request from the control register (synchronous) |
| drv_const_mode | input | 1 | 1 selects the constant-current driver-supply mode |
| hi_at | input | 1 | High boost rail at programmed target |
| hi_80 | input | 1 | High boost rail above 80 percent |
| aux_at | input | 1 | Secondary boost rail at programmed target |
| drv_80 | input | 1 | Driver-supply rail above 80 percent |
| sub_80 | input | 1 | Substrate rail above 80 percent |
| base_ok | input | 1 | Base-voltage rail at its level |
| supply_ready | output | 1 | All supplies usable; enables the line drivers |
| start_busy | output | 1 | Start-up status pin, inverse of supply_ready |
| conv_en | output | 1 | Converter enable, 0 in power-down |
| aux_chg_en | output | 1 | Charging path enable for the secondary boost rail |
| drv_boost | output | 1 | Extra output current request for the driver-supply amplifier |

## Verification
Every comparator flag and the power-down pin act on the outputs at the third rising edge after they are applied, and the register power-down bit acts at the first. Each stimulus is therefore driven just after a falling edge. Directed checks sample at the falling edge one edge before the expected change and again at the falling edge right after it, so an off-by-one in the synchronizer or the state register is reported. The mode input changes the boost request in the same cycle and is checked one time unit after it is driven. During the random phase a cycle-level reference kept in the bench, built from the requirements with its own two-deep flag history, is compared with all outputs at every falling edge.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

   typedef enum logic [1:0] {
      ST_OFF     = 2'd0,
      ST_CHG_HI  = 2'd1,
      ST_CHG_AUX = 2'd2,
      ST_RDY     = 2'd3
   } sup_state_e;

   typedef struct packed {
      logic pwrdn_pin;
      logic hi_at;
      logic hi_80;
      logic aux_at;
      logic drv_80;
      logic sub_80;
      logic base_ok;
   } rail_flags_t;

   localparam int FLAG_W = $bits(rail_flags_t);

   // the pin request resets to "down" so power-on reset lands in power-down
   localparam rail_flags_t FLAG_RST = '{pwrdn_pin: 1'b1, default: 1'b0};

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
   parameter int              WIDTH   = 1,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
         $error("rsup_sync: STAGES must be 2 to 4");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("rsup_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= {STAGES{RST_VAL}};
      end else begin
         pipe_q <= {pipe_q[STAGES-2:0], d};
      end
   end

   assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/rsup_fsm.sv
module rsup_fsm
   import rsup_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        pwrdn,
   input  rail_flags_t flg,
   output sup_state_e  state,
   output logic        aux_done,
   output logic        base_seen
);

   sup_state_e state_nx;
   logic       aux_done_nx;
   logic       base_seen_nx;
   logic       keep_ready;
   logic       may_ready;

   // loss of ready uses only the 80 percent flags (hysteresis)
   assign keep_ready = flg.hi_80 & flg.drv_80 & flg.sub_80;
   assign may_ready  = flg.hi_at & flg.drv_80 & flg.sub_80 & (aux_done | flg.aux_at);

   always_comb begin
      state_nx     = state;
      aux_done_nx  = aux_done;
      base_seen_nx = base_seen;
      if (pwrdn) begin
         state_nx     = ST_OFF;
         aux_done_nx  = 1'b0;
         base_seen_nx = 1'b0;
      end else begin
         unique case (state)
            ST_OFF: begin
               state_nx     = ST_CHG_HI;
               aux_done_nx  = 1'b0;
               base_seen_nx = 1'b0;
            end
            ST_CHG_HI: begin
               if (flg.base_ok) base_seen_nx = 1'b1;
               if (flg.hi_at)   state_nx     = ST_CHG_AUX;
            end
            ST_CHG_AUX: begin
               if (flg.base_ok) base_seen_nx = 1'b1;
               if (flg.aux_at)  aux_done_nx  = 1'b1;
               if (may_ready)   state_nx     = ST_RDY;
            end
            ST_RDY: begin
               if (!keep_ready) begin
                  state_nx     = ST_CHG_HI;
                  base_seen_nx = 1'b0;
               end
            end
            default: state_nx = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_OFF;
         aux_done  <= 1'b0;
         base_seen <= 1'b0;
      end else begin
         state     <= state_nx;
         aux_done  <= aux_done_nx;
         base_seen <= base_seen_nx;
      end
   end

endmodule

// File: rtl/rsup_outdec.sv
module rsup_outdec
   import rsup_pkg::*;
(
   input  sup_state_e state,
   input  logic       base_seen,
   input  logic       const_mode,
   output logic       ready,
   output logic       busy,
   output logic       conv_on,
   output logic       aux_en,
   output logic       boost
);

   always_comb begin
      ready   = (state == ST_RDY);
      busy    = ~ready;
      conv_on = (state != ST_OFF);
      aux_en  = (state == ST_CHG_AUX) || (state == ST_RDY);
      boost   = conv_on & (const_mode | (~ready & ~base_seen));
   end

endmodule

// File: rtl/rail_startup_supervisor.sv
module rail_startup_supervisor
   import rsup_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwrdn_pin,
   input  logic pwrdn_reg,
   input  logic drv_const_mode,
   input  logic hi_at,
   input  logic hi_80,
   input  logic aux_at,
   input  logic drv_80,
   input  logic sub_80,
   input  logic base_ok,
   output logic supply_ready,
   output logic start_busy,
   output logic conv_en,
   output logic aux_chg_en,
   output logic drv_boost
);

   rail_flags_t flg_raw;
   rail_flags_t flg_s;
   sup_state_e  state;
   logic        aux_done;
   logic        base_seen;
   logic        pwrdn;

   assign flg_raw = '{pwrdn_pin: pwrdn_pin, hi_at: hi_at, hi_80: hi_80,
                      aux_at: aux_at, drv_80: drv_80, sub_80: sub_80,
                      base_ok: base_ok};

   rsup_sync #(
      .WIDTH   (FLAG_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (FLAG_RST)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (flg_raw),
      .q     (flg_s)
   );

   assign pwrdn = pwrdn_reg | flg_s.pwrdn_pin;

   rsup_fsm fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwrdn     (pwrdn),
      .flg       (flg_s),
      .state     (state),
      .aux_done  (aux_done),
      .base_seen (base_seen)
   );

   rsup_outdec dec_i (
      .state      (state),
      .base_seen  (base_seen),
      .const_mode (drv_const_mode),
      .ready      (supply_ready),
      .busy       (start_busy),
      .conv_on    (conv_en),
      .aux_en     (aux_chg_en),
      .boost      (drv_boost)
   );

endmodule

// File: rtl/rsup_checker.sv
module rsup_checker #(
   parameter int SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic pwrdn_reg,
   input logic drv_const_mode,
   input logic hi_at,
   input logic drv_80,
   input logic sub_80,
   input logic supply_ready,
   input logic start_busy,
   input logic conv_en,
   input logic aux_chg_en,
   input logic drv_boost
);

   localparam int LAT = SYNC_STAGES + 1;

   p_busy_inverse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_busy == !supply_ready);

   p_reg_pwrdn_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pwrdn_reg |=> (!conv_en && !supply_ready && !aux_chg_en && !drv_boost));

   p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_en |-> (!supply_ready && !aux_chg_en && !drv_boost));

   p_ready_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(supply_ready) |-> ($past(hi_at, LAT) && $past(drv_80, LAT) && $past(sub_80, LAT)));

   p_ready_aux_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
      supply_ready |-> aux_chg_en);

   p_boost_const_r10: assert property (@(posedge clk) disable iff (!rst_n)
      drv_const_mode |-> (drv_boost == conv_en));

   p_boost_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_ready && !drv_const_mode) |-> !drv_boost);

endmodule

bind rail_startup_supervisor rsup_checker #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .pwrdn_reg      (pwrdn_reg),
   .drv_const_mode (drv_const_mode),
   .hi_at          (hi_at),
   .drv_80         (drv_80),
   .sub_80         (sub_80),
   .supply_ready   (supply_ready),
   .start_busy     (start_busy),
   .conv_en        (conv_en),
   .aux_chg_en     (aux_chg_en),
   .drv_boost      (drv_boost)
);

// File: tb/rail_startup_supervisor_tb.sv
module rail_startup_supervisor_tb_top;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic rst_n = 1'b0;
   logic pwrdn_pin = 1'b0, pwrdn_reg = 1'b0, drv_const_mode = 1'b0;
   logic hi_at = 1'b0, hi_80 = 1'b0, aux_at = 1'b0;
   logic drv_80 = 1'b0, sub_80 = 1'b0, base_ok = 1'b0;
   logic supply_ready, start_busy, conv_en, aux_chg_en, drv_boost;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   rail_startup_supervisor dut_i (
      .clk(clk), .rst_n(rst_n), .pwrdn_pin(pwrdn_pin), .pwrdn_reg(pwrdn_reg),
      .drv_const_mode(drv_const_mode), .hi_at(hi_at), .hi_80(hi_80),
      .aux_at(aux_at), .drv_80(drv_80), .sub_80(sub_80), .base_ok(base_ok),
      .supply_ready(supply_ready), .start_busy(start_busy), .conv_en(conv_en),
      .aux_chg_en(aux_chg_en), .drv_boost(drv_boost)
   );

   // reference: two-deep flag history, then phase 0 off, 1 high-rail charge,
   // 2 secondary charge, 3 ready
   logic [6:0] in_vec;
   logic [6:0] h1, h2;
   int  m_st;
   bit  m_aux, m_base;

   assign in_vec = {pwrdn_pin, hi_at, hi_80, aux_at, drv_80, sub_80, base_ok};

   always @(posedge clk or negedge rst_n) begin : model_blk
      int nst;
      bit naux, nbase, pd;
      if (!rst_n) begin
         h1 <= 7'b1000000; h2 <= 7'b1000000;
         m_st <= 0; m_aux <= 1'b0; m_base <= 1'b0;
      end else begin
         nst = m_st; naux = m_aux; nbase = m_base;
         pd = pwrdn_reg | h2[6];
         if (pd) begin
            nst = 0; naux = 1'b0; nbase = 1'b0;
         end else begin
            case (m_st)
               0: nst = 1;
               1: begin
                  if (h2[0]) nbase = 1'b1;
                  if (h2[5]) nst = 2;
               end
               2: begin
                  if (h2[0]) nbase = 1'b1;
                  if (h2[3]) naux = 1'b1;
                  if (h2[5] && h2[2] && h2[1] && (m_aux || h2[3])) nst = 3;
               end
               default: begin
                  if (!(h2[4] && h2[2] && h2[1])) begin nst = 1; nbase = 1'b0; end
               end
            endcase
         end
         h1 <= in_vec; h2 <= h1;
         m_st <= nst; m_aux <= naux; m_base <= nbase;
      end
   end

   task automatic chk1(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic expect_out(string tag, logic r, logic c, logic a, logic b);
      chk1(tag, "supply_ready", supply_ready, r);
      chk1(tag, "start_busy",   start_busy,   ~r);
      chk1(tag, "conv_en",      conv_en,      c);
      chk1(tag, "aux_chg_en",   aux_chg_en,   a);
      chk1(tag, "drv_boost",    drv_boost,    b);
   endtask

   function automatic logic [4:0] model_out();
      logic r, c, a, b;
      r = (m_st == 3);
      c = (m_st != 0);
      a = (m_st >= 2);
      b = c && (drv_const_mode || (!r && !m_base));
      return {r, c, a, b, ~r};
   endfunction

   task automatic cmp_model(string tag);
      logic [4:0] e;
      e = model_out();
      chk1(tag, "supply_ready", supply_ready, e[4]);
      chk1(tag, "conv_en",      conv_en,      e[3]);
      chk1(tag, "aux_chg_en",   aux_chg_en,   e[2]);
      chk1(tag, "drv_boost",    drv_boost,    e[1]);
      chk1(tag, "start_busy",   start_busy,   e[0]);
   endtask

   task automatic edges(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL WDOG run did not end actual=running expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h1d5e_7a21));
      repeat (3) @(negedge clk);
      expect_out("R1 in reset", 1'b0, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      edges(2);
      expect_out("R1 R11 still off", 1'b0, 1'b0, 1'b0, 1'b0);
      edges(1);
      expect_out("R4 R11 charge high", 1'b0, 1'b1, 1'b0, 1'b1);

      hi_80 = 1'b1; drv_80 = 1'b1; sub_80 = 1'b1; aux_at = 1'b1;
      edges(5);
      expect_out("R4 aux ignored early", 1'b0, 1'b1, 1'b0, 1'b1);

      aux_at = 1'b0; hi_at = 1'b1;
      edges(2);
      expect_out("R11 aux path not yet", 1'b0, 1'b1, 1'b0, 1'b1);
      edges(1);
      expect_out("R4 aux path open", 1'b0, 1'b1, 1'b1, 1'b1);
      edges(3);
      expect_out("R5 no ready without aux", 1'b0, 1'b1, 1'b1, 1'b1);

      aux_at = 1'b1;
      edges(2);
      expect_out("R11 ready not yet", 1'b0, 1'b1, 1'b1, 1'b1);
      edges(1);
      expect_out("R5 R3 R9 ready", 1'b1, 1'b1, 1'b1, 1'b0);

      aux_at = 1'b0;
      edges(5);
      expect_out("R6 aux drop ignored", 1'b1, 1'b1, 1'b1, 1'b0);

      hi_at = 1'b0;
      edges(5);
      expect_out("R8 hysteresis holds", 1'b1, 1'b1, 1'b1, 1'b0);

      sub_80 = 1'b0;
      edges(2);
      expect_out("R7 sag not yet", 1'b1, 1'b1, 1'b1, 1'b0);
      edges(1);
      expect_out("R7 R9 sag restart", 1'b0, 1'b1, 1'b0, 1'b1);

      sub_80 = 1'b1; hi_at = 1'b1;
      edges(3);
      expect_out("R6 restart aux phase", 1'b0, 1'b1, 1'b1, 1'b1);
      edges(1);
      expect_out("R6 latch kept", 1'b1, 1'b1, 1'b1, 1'b0);

      pwrdn_reg = 1'b1;
      edges(1);
      expect_out("R2 register pwrdn", 1'b0, 1'b0, 1'b0, 1'b0);
      pwrdn_reg = 1'b0;
      edges(1);
      expect_out("R4 leave pwrdn", 1'b0, 1'b1, 1'b0, 1'b1);
      edges(1);
      expect_out("R12 aux phase", 1'b0, 1'b1, 1'b1, 1'b1);
      edges(5);
      expect_out("R12 latch cleared", 1'b0, 1'b1, 1'b1, 1'b1);

      base_ok = 1'b1;
      edges(2);
      expect_out("R11 base not yet", 1'b0, 1'b1, 1'b1, 1'b1);
      edges(1);
      expect_out("R9 base released", 1'b0, 1'b1, 1'b1, 1'b0);

      drv_const_mode = 1'b1;
      #1;
      expect_out("R10 const mode", 1'b0, 1'b1, 1'b1, 1'b1);

      pwrdn_pin = 1'b1;
      edges(2);
      expect_out("R11 pin not yet", 1'b0, 1'b1, 1'b1, 1'b1);
      edges(1);
      expect_out("R2 pin pwrdn", 1'b0, 1'b0, 1'b0, 1'b0);

      pwrdn_pin = 1'b0; drv_const_mode = 1'b0; base_ok = 1'b0;
      edges(1);
      cmp_model("RND settle");

      for (int cyc = 0; cyc < 4000; cyc++) begin
         if ($urandom_range(7) == 0) begin
            case ($urandom_range(5))
               0: hi_at  = ~hi_at;
               1: hi_80  = ~hi_80;
               2: aux_at = ~aux_at;
               3: drv_80 = ~drv_80;
               4: sub_80 = ~sub_80;
               default: base_ok = ~base_ok;
            endcase
         end
         if ($urandom_range(63) == 0)  pwrdn_reg = ~pwrdn_reg;
         if ($urandom_range(127) == 0) pwrdn_pin = ~pwrdn_pin;
         if ($urandom_range(31) == 0)  drv_const_mode = ~drv_const_mode;
         #1;
         cmp_model("RND mode");
         edges(1);
         cmp_model("RND");
      end

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule